// File: doc/BRIEF.md
# SPI Master Controller

A register-programmed SPI master. Software selects one of three chip-select lines, the clock mode and a clock divider, loads bytes into a 16-entry transmit FIFO through a single data port, and then sets a transfer-enable bit. While that bit is set, the engine takes bytes from the transmit FIFO one at a time. It shifts each byte out MSB first on `mosi` and assembles the byte arriving on `miso` into a 16-entry receive FIFO. Software drains that FIFO through the same data port.

The engine drives the selected chip-select line to its active level for as long as the transfer-enable bit stays set. Each line has its own polarity bit. The serial clock is the core clock divided by an even number taken from the divider register. One interrupt line reports two conditions, each with its own enable: the transfer has finished, or the receive FIFO needs draining.

Top module: `spi_master_mm`

## Requirements
- R1: After reset the control/status word reads 0x0004_0000 (only "TX has room" set), the divider reads 0, `cs_o` is 3'b111, `sclk` is 0 and `irq` is 0.
- R2: Register addresses: 0 is control/status, 1 is the FIFO data port, 2 is the divider (low 16 bits). Control fields: [1:0] line select, [2] CPHA, [3] CPOL, [7] transfer enable (TA), [9] done-interrupt enable, [10] receive-interrupt enable, [23:21] polarity of lines 2..0 (bit 21+k for line k). These fields read back as written.
- R3: `sclk` rests at CPOL whenever no byte is shifting. With CPHA=0, data is sampled on the leading edge and changed on the trailing edge. With CPHA=1, the roles of the two edges swap. Bytes go out and come in MSB first, in all four modes.
- R4: One `sclk` period lasts D core cycles, where D is the divider value rounded down to even. A value of 0 or 1 gives 65536 cycles.
- R5: Line k is at its active level (its polarity bit) only while TA=1 and the line select equals k. Otherwise it sits at the inverse of its polarity bit. A line select of 3 drives no line active.
- R6: A control write with TA=0 returns every line to inactive and `sclk` to CPOL by the next cycle. It discards any partly shifted byte.
- R7: The engine starts no byte while the receive FIFO holds 16 entries. It resumes once software reads one entry.
- R8: Writing 1 to control bit 4 empties the transmit FIFO, and writing 1 to bit 5 empties the receive FIFO. Both bits read as 0.
- R9: A data write while the transmit FIFO holds 16 bytes is dropped. Status bit 18 is 1 exactly when the transmit FIFO has room.
- R10: Status bits: 16 is done (TA=1, transmit FIFO empty, no byte shifting), 17 is receive FIFO not empty, 19 is receive FIFO holding 12 or more entries, 20 is receive FIFO full.
- R11: `irq` = (bit 9 AND done) OR (bit 10 AND bit 19).
- R12: A read of the data port returns the oldest received byte in bits [7:0] (upper bits 0) and removes it. A read of an empty FIFO returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive FIFO at address 1) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | 3 | Chip-select lines, polarity per line |

## Verification
The bench goes after the following corner cases:

- **All four clock modes.** A slave model samples on the edge that the mode dictates. An engine that samples or shifts on the wrong edge delivers bytes shifted by one bit.
- **Receive FIFO full.** A byte is left waiting in the transmit FIFO while the receive FIFO is full. A design without the stall would overrun the FIFO or lose bytes.
- **Transmit FIFO full.** A seventeenth write is made to a full transmit FIFO. A design that accepts it puts an unexpected byte on the wire.
- **Divider values.** An odd value and the zero value are both measured. A design that skips the rounding, or treats 0 literally, produces the wrong `sclk` period.
- **Polarity and line select.** Per-line polarity, line select 3 and a mid-byte stop are all checked at `cs_o` and `sclk`. A design that lets a stopped byte reach the receive FIFO is also caught.

// File: rtl/spi_master_mm.sv
module spi_master_mm #(
  parameter int DEPTH = 16,
  parameter int RX_HI = 12,
  parameter int DIVW  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic [2:0]  cs_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [DIVW-1:0] HALF_MAX = DIVW'(1) << (DIVW - 1);

  logic [1:0]      cs_sel;
  logic            cpha, cpol, ta, intd, intr;
  logic [2:0]      pol;
  logic [DIVW-1:0] div;

  logic [7:0]    txm [DEPTH];
  logic [7:0]    rxm [DEPTH];
  logic [AW-1:0] tx_rp, tx_wp, rx_rp, rx_wp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  logic            busy, ph;
  logic [DIVW-1:0] cnt, half;
  logic [3:0]      edge_n;
  logic [7:0]      tx_sh, rx_sh, rx_next, rx_byte;

  logic wr_ctl, wr_dat, wr_div, rd_dat;
  logic tx_empty, tx_full, rx_empty, rx_full;
  logic clr_tx, clr_rx, stop, start, tick, samp, shft, byte_end;
  logic tx_push, rx_push, rx_pop, done, rxr;
  logic unused_wbits;

  assign wr_ctl = bus_wr && (bus_addr == 2'd0);
  assign wr_dat = bus_wr && (bus_addr == 2'd1);
  assign wr_div = bus_wr && (bus_addr == 2'd2);
  assign rd_dat = bus_rd && (bus_addr == 2'd1);
  assign unused_wbits = ^{bus_wdata[31:24], bus_wdata[20:11], bus_wdata[8], bus_wdata[6]};

  assign tx_empty = (tx_cnt == '0);
  assign tx_full  = (tx_cnt == CW'(DEPTH));
  assign rx_empty = (rx_cnt == '0);
  assign rx_full  = (rx_cnt == CW'(DEPTH));

  assign clr_tx  = wr_ctl && bus_wdata[4];
  assign clr_rx  = wr_ctl && bus_wdata[5];
  assign stop    = wr_ctl && !bus_wdata[7];
  assign tx_push = wr_dat && !tx_full;
  assign rx_pop  = rd_dat && !rx_empty;
  assign start   = ta && !stop && !busy && !tx_empty && !rx_full && !clr_tx;

  assign half     = (div[DIVW-1:1] == '0) ? HALF_MAX : {1'b0, div[DIVW-1:1]};
  assign tick     = busy && (cnt == '0);
  assign samp     = (edge_n[0] == cpha);
  assign shft     = !samp && (edge_n != 4'd0);
  assign rx_next  = {rx_sh[6:0], miso};
  assign byte_end = tick && (edge_n == 4'hF);
  assign rx_byte  = samp ? rx_next : rx_sh;
  assign rx_push  = byte_end && !stop;

  assign done = ta && tx_empty && !busy;
  assign rxr  = (rx_cnt >= CW'(RX_HI));
  assign irq  = (intd && done) || (intr && rxr);
  assign sclk = cpol ^ ph;
  assign mosi = tx_sh[7];

  for (genvar k = 0; k < 3; k++) begin : g_cs
    assign cs_o[k] = (ta && cs_sel == 2'(k)) ? pol[k] : ~pol[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sel <= '0; cpha <= 1'b0; cpol <= 1'b0; ta <= 1'b0;
      intd <= 1'b0; intr <= 1'b0; pol <= '0; div <= '0;
    end else begin
      if (wr_ctl) begin
        cs_sel <= bus_wdata[1:0];
        cpha   <= bus_wdata[2];
        cpol   <= bus_wdata[3];
        ta     <= bus_wdata[7];
        intd   <= bus_wdata[9];
        intr   <= bus_wdata[10];
        pol    <= bus_wdata[23:21];
      end
      if (wr_div) div <= bus_wdata[DIVW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; ph <= 1'b0; cnt <= '0; edge_n <= '0;
      tx_sh <= '0; rx_sh <= '0;
    end else if (stop || !ta) begin
      busy <= 1'b0;
      ph   <= 1'b0;
    end else if (start) begin
      busy   <= 1'b1;
      ph     <= 1'b0;
      tx_sh  <= txm[tx_rp];
      cnt    <= half - 1'b1;
      edge_n <= '0;
    end else if (tick) begin
      ph     <= ~ph;
      edge_n <= edge_n + 1'b1;
      cnt    <= half - 1'b1;
      if (samp) rx_sh <= rx_next;
      if (shft) tx_sh <= {tx_sh[6:0], 1'b0};
      if (byte_end) busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_rp <= '0; tx_wp <= '0; tx_cnt <= '0;
    end else if (clr_tx) begin
      tx_rp <= '0; tx_wp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (start)   tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(start);
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) txm[tx_wp] <= bus_wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_rp <= '0; rx_wp <= '0; rx_cnt <= '0;
    end else if (clr_rx) begin
      rx_rp <= '0; rx_wp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (rx_push) rxm[rx_wp] <= rx_byte;
  end

  always_comb begin
    case (bus_addr)
      2'd0: bus_rdata = {8'h00, pol, rx_full, rxr, !tx_full, !rx_empty, done,
                         5'b0, intr, intd, 1'b0, ta, 3'b0, cpol, cpha, cs_sel};
      2'd1: bus_rdata = {24'h0, rx_empty ? 8'h00 : rxm[rx_rp]};
      2'd2: bus_rdata = {{(32-DIVW){1'b0}}, div};
      default: bus_rdata = '0;
    endcase
  end
endmodule

module spi_master_mm_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       ta,
  input logic                       busy,
  input logic                       cpol,
  input logic                       sclk,
  input logic [2:0]                 cs_o,
  input logic [2:0]                 pol,
  input logic [$clog2(DEPTH):0]     tx_cnt,
  input logic [$clog2(DEPTH):0]     rx_cnt,
  input logic                       bus_wr,
  input logic [1:0]                 bus_addr,
  input logic [31:0]                bus_wdata
);
  localparam int CW = $clog2(DEPTH) + 1;

  a_r5_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~(cs_o ^ pol)));

  a_r5_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
    !ta |-> (cs_o == ~pol));

  a_r3_sclk_rest: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == cpol));

  a_r9_fifo_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

  a_r8_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && bus_wdata[5]) |=> (rx_cnt == '0));

  a_r6_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && !bus_wdata[7]) |=> (!busy && cs_o == ~pol));

  a_r7_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(ta) && $past(rx_cnt) != CW'(DEPTH)));
endmodule

bind spi_master_mm spi_master_mm_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ta(ta), .busy(busy), .cpol(cpol), .sclk(sclk),
  .cs_o(cs_o), .pol(pol), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/spi_master_mm_tb.sv
`timescale 1ns/1ps
module spi_master_mm_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq, sclk, mosi, miso;
  logic [2:0] cs_o;

  always #2 clk = ~clk;

  spi_master_mm dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_o(cs_o)
  );

  localparam logic [31:0] TA = 32'h80, INTD = 32'h200, INTR = 32'h400;
  localparam logic [31:0] CLRTX = 32'h10, CLRRX = 32'h20;
  localparam logic [31:0] S_DONE = 32'h1_0000, S_RXD = 32'h2_0000, S_TXD = 32'h4_0000;
  localparam logic [31:0] S_RXR = 32'h8_0000, S_RXF = 32'h10_0000;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic       tb_cpol = 1'b0, tb_cpha = 1'b0;
  logic [1:0] tb_sel = 2'd0;
  logic [2:0] tb_pol = 3'b000;

  logic [7:0] exp_mosi[$];
  logic [7:0] resp_q[$];
  logic [7:0] exp_miso[$];
  logic [7:0] s_in = '0, s_cur = '0;
  logic [2:0] s_bit = '0;
  logic cs_act;

  assign cs_act = rst_n && (tb_sel != 2'd3) && (cs_o[tb_sel] == tb_pol[tb_sel]);
  assign miso = cs_act ? s_cur[3'd7 - s_bit] : 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic refresh();
    s_cur = (resp_q.size() > 0) ? resp_q[0] : 8'h00;
  endtask

  always @(posedge cs_act) begin
    s_bit = '0;
    refresh();
  end

  // slave monitor: samples on the mode's sampling edge and scores each MOSI byte
  always @(sclk) begin
    if (cs_act && ((sclk != tb_cpol) == !tb_cpha)) begin
      s_in = {s_in[6:0], mosi};
      if (s_bit == 3'd7) begin
        s_bit = '0;
        if (exp_mosi.size() == 0) chk("R3/R9 unexpected mosi byte", {24'h0, s_in}, 32'hxxxx_xxxx);
        else chk("R3 mosi byte", {24'h0, s_in}, {24'h0, exp_mosi.pop_front()});
        if (resp_q.size() > 0) void'(resp_q.pop_front());
        refresh();
      end else begin
        s_bit = s_bit + 3'd1;
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic logic [31:0] cfg();
    return {8'h0, tb_pol, 13'h0, 4'h0, tb_cpol, tb_cpha, tb_sel};
  endfunction

  task automatic send(input logic [7:0] b);
    logic [7:0] r;
    r = {b[3:0], b[7:4]} ^ 8'h96;
    exp_mosi.push_back(b);
    resp_q.push_back(r);
    exp_miso.push_back(r);
    refresh();
    wr(2'd1, {24'h0, b});
  endtask

  task automatic drain(input int n, input string req);
    logic [31:0] d;
    for (int i = 0; i < n; i++) begin
      rd(2'd1, d);
      if (exp_miso.size() == 0) chk(req, d, 32'hxxxx_xxxx);
      else chk(req, d, {24'h0, exp_miso.pop_front()});
    end
  endtask

  task automatic wait_bit(input logic [31:0] m, input string req);
    logic [31:0] d;
    int k = 0;
    rd(2'd0, d);
    while ((d & m) == 0 && k < 5000) begin
      rd(2'd0, d);
      k++;
    end
    if ((d & m) == 0) chk(req, d & m, m);
  endtask

  task automatic flush_model();
    exp_mosi.delete(); resp_q.delete(); exp_miso.delete();
    refresh();
  endtask

  initial begin
    #(4 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int t1, t2;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); chk("R1 status", d, 32'h0004_0000);
    rd(2'd2, d); chk("R1 divider", d, 32'h0);
    chk("R1 cs_o", {29'h0, cs_o}, 32'h7);
    chk("R1 sclk", {31'h0, sclk}, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R2 field readback
    wr(2'd0, 32'h00E0_060E);
    rd(2'd0, d); chk("R2 control readback", d, 32'h00E4_060E);
    wr(2'd2, 32'h1234_5678);
    rd(2'd2, d); chk("R2 divider readback", d, 32'h0000_5678);
    chk("R11 irq with TA off", {31'h0, irq}, 32'h0);
    wr(2'd0, 32'h0);
    wr(2'd2, 32'd4);

    // R3 all four modes, R5 line 0 active-low, R10/R11 done interrupt
    for (int m = 0; m < 4; m++) begin
      tb_cpha = m[0]; tb_cpol = m[1]; tb_sel = 2'd0; tb_pol = 3'b000;
      wr(2'd0, cfg());
      chk("R3 sclk rests at CPOL", {31'h0, sclk}, {31'h0, tb_cpol});
      send(8'hA5 ^ 8'(m * 17)); send(8'h3C + 8'(m)); send(8'h81);
      wr(2'd0, cfg() | TA | INTD);
      chk("R5 line 0 active", {29'h0, cs_o}, 32'h6);
      wait_bit(S_DONE, "R10 done timeout");
      chk("R11 irq on done", {31'h0, irq}, 32'h1);
      drain(3, "R3 miso byte R12");
      wr(2'd0, cfg());
      chk("R11 irq cleared", {31'h0, irq}, 32'h0);
    end

    // R5 per-line polarity and line select 3
    tb_cpha = 1'b0; tb_cpol = 1'b0; tb_sel = 2'd2; tb_pol = 3'b100;
    wr(2'd0, cfg());
    chk("R5 inactive with pol2", {29'h0, cs_o}, 32'h3);
    send(8'h5E);
    wr(2'd0, cfg() | TA);
    chk("R5 line 2 active high", {29'h0, cs_o}, 32'h7);
    wait_bit(S_DONE, "R5 done timeout");
    drain(1, "R5 miso byte");
    wr(2'd0, cfg());
    chk("R5 line 2 released", {29'h0, cs_o}, 32'h3);
    tb_sel = 2'd3;
    wr(2'd0, cfg() | TA);
    chk("R5 select 3 drives none", {29'h0, cs_o}, 32'h3);
    tb_sel = 2'd0; tb_pol = 3'b000;
    wr(2'd0, cfg());

    // R9 transmit full, R7 receive stall, R10/R11 receive threshold
    for (int i = 0; i < 16; i++) send(8'(8'h10 + i * 3));
    rd(2'd0, d); chk("R9 no room when full", d & S_TXD, 32'h0);
    wr(2'd1, 32'hEE);
    wr(2'd0, cfg() | TA | INTR);
    wait_bit(S_RXF, "R7 rx full timeout");
    send(8'h77);
    repeat (200) @(negedge clk);
    rd(2'd0, d); chk("R7 stalled while full", d & (S_DONE | S_RXF | S_RXR), S_RXF | S_RXR);
    chk("R7 sclk idle during stall", {31'h0, sclk}, 32'h0);
    chk("R11 irq on rx threshold", {31'h0, irq}, 32'h1);
    drain(16, "R12 fifo order");
    wait_bit(S_DONE, "R7 resume timeout");
    chk("R9 dropped byte not sent", exp_mosi.size(), 32'h0);
    rd(2'd0, d); chk("R10 status after resume", d, 32'h0007_0480);
    chk("R11 irq below threshold", {31'h0, irq}, 32'h0);
    drain(1, "R7 resumed byte");
    wr(2'd0, cfg());

    // R8 FIFO clears
    wr(2'd1, 32'h11); wr(2'd1, 32'h22); wr(2'd1, 32'h33);
    wr(2'd0, cfg() | CLRTX);
    rd(2'd0, d); chk("R8 tx cleared, bits self-clear", d, 32'h0004_0000);
    wr(2'd0, cfg() | TA);
    repeat (40) @(negedge clk);
    rd(2'd0, d); chk("R10 done with empty tx", d, 32'h0005_0080);
    chk("R8 nothing shifted", {31'h0, sclk}, 32'h0);
    wr(2'd0, cfg());
    send(8'hC3); send(8'h4B);
    wr(2'd0, cfg() | TA);
    wait_bit(S_DONE, "R8 done timeout");
    wr(2'd0, cfg());
    rd(2'd0, d); chk("R10 rx not empty", d, 32'h0006_0000);
    wr(2'd0, cfg() | CLRRX);
    rd(2'd0, d); chk("R8 rx cleared", d, 32'h0004_0000);
    rd(2'd1, d); chk("R12 empty read is zero", d, 32'h0);
    flush_model();

    // R6 stop mid-byte
    send(8'h96);
    wr(2'd0, cfg() | TA);
    @(posedge sclk);
    wr(2'd0, cfg());
    chk("R6 sclk back to rest", {31'h0, sclk}, 32'h0);
    chk("R6 line released", {29'h0, cs_o}, 32'h7);
    repeat (50) @(negedge clk);
    rd(2'd0, d); chk("R6 partial byte discarded", d & S_RXD, 32'h0);
    flush_model();

    // R4 odd divider rounds down
    wr(2'd2, 32'd7);
    send(8'h69);
    wr(2'd0, cfg() | TA);
    @(posedge sclk); t1 = cyc;
    @(posedge sclk); t2 = cyc;
    chk("R4 divider 7 period", t2 - t1, 32'd6);
    wait_bit(S_DONE, "R4 done timeout");
    drain(1, "R4 miso byte");
    wr(2'd0, cfg());

    // R4 zero divider means 65536
    wr(2'd2, 32'd0);
    send(8'hF0);
    wr(2'd0, cfg() | TA);
    @(posedge sclk); t1 = cyc;
    @(negedge sclk); t2 = cyc;
    chk("R4 divider 0 half period", t2 - t1, 32'd32768);
    wr(2'd0, cfg());
    flush_model();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule